// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 8 bits. The host raises a one-cycle request with a write flag, a 17-bit address and, for a write, a data byte. The controller then produces the strobe sequence the memory needs. The memory side has two chip selects: `mem_ce1_n` is active low and `mem_ce2` is active high. It also has an active-low output enable, an active-low write enable, and a data bus split into output, output-enable and input. The host is told that the transfer is over by a one-cycle `rsp_done` pulse.

Every timing minimum the memory imposes is a nanosecond parameter. It is turned into a whole number of clock cycles as ceil(ns / clock period), and any nonzero value takes at least one cycle. A write asserts both chip selects first and holds the address. It then lowers write enable for long enough to meet the pulse width, the address-to-end, the select-to-end and the data-setup minimums. The data bus is driven only while write enable is low. The write ends when write enable rises, and a recovery gap follows so that the whole cycle meets the write cycle time. A read asserts both selects and output enable together and samples the bus once both the address access time and the output-enable access time have passed.

Requests are taken only when the controller is idle. A request at any other time is dropped. Read data stays on `rsp_rdata` until a later read completes.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_done`=0.
- R2: When an operation has finished and the controller is idle, the memory is deselected with `mem_oe_n`=1 and `mem_we_n`=1.
- R3: A write holds `mem_we_n` low only while `mem_ce1_n`=0, `mem_ce2`=1 and `mem_oe_n`=1. The low pulse lasts at least ceil(tWP) cycles. The selects are active for at least ceil(tCW) cycles up to the rising edge of `mem_we_n`. The byte on `mem_dq_out` at that edge is stored at `mem_addr`.
- R4: `mem_dq_oe` is asserted only while `mem_we_n` is low (the hold time is 0 by default) and never while `mem_oe_n` is low. It rises no earlier than the cycle after `mem_we_n` falls, and it is high for at least ceil(tDW) cycles before `mem_we_n` rises.
- R5: `mem_addr` changes only at an edge where the memory was deselected and `mem_we_n` was high. It stays constant while the selects are active.
- R6: A read drives `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1. `rsp_rdata` takes the bus value sampled max(ceil(tAA), ceil(tOE)) cycles after the strobes were asserted.
- R7: `rsp_done` is high for exactly one cycle per accepted request. It comes at least ceil(tWC) cycles after the accept edge for a write and at least ceil(tRC) cycles after it for a read.
- R8: A request raised while an operation is in progress is ignored. It produces no memory access and no `rsp_done`.
- R9: `rsp_rdata` keeps its value through write operations and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for data bus |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The hardest case to reach from the ports is a request that arrives while a write pulse is already under way. That request must leave no trace. The bench raises a second write to the same address, with different data, a few cycles into the pulse. It then reads the address back and counts completion pulses.

The memory model in the bench returns the inverse of the stored byte until the read strobes have been active for ceil(tAA) cycles. A read sampled too early therefore shows up as a data mismatch. The model also times every write overlap and the data-drive window against the rounded-up minimums.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WHLD, ST_WREC, ST_RACC, ST_RREC
  } ctl_state_t;

  // whole cycles covering a nanosecond interval; zero stays zero
  function automatic int ns2cyc(input int ns, input int per);
    if (ns <= 0) return 0;
    return (ns + per - 1) / per;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_ctl_pkg::*;
#(
  parameter int SETUP_N = 1,
  parameter int PULSE_N = 14,
  parameter int HOLD_N  = 0,
  parameter int WREC_N  = 3,
  parameter int SAMP_N  = 18,
  parameter int RREC_N  = 1,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tm_zero,
  output logic             tm_load,
  output logic [CNT_W-1:0] tm_val,
  output logic             accept,
  output logic             capture,
  output logic             ce1_n,
  output logic             ce2,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             done
);
  ctl_state_t st, st_nxt;
  logic sel_nxt, rd_nxt, wr_nxt, drv_nxt;

  always_comb begin
    st_nxt  = st;
    tm_load = 1'b0;
    tm_val  = '0;
    case (st)
      ST_IDLE: if (req) begin
        tm_load = 1'b1;
        if (req_wr) begin st_nxt = ST_WSET; tm_val = CNT_W'(SETUP_N - 1); end
        else        begin st_nxt = ST_RACC; tm_val = CNT_W'(SAMP_N - 1);  end
      end
      ST_WSET: if (tm_zero) begin
        st_nxt = ST_WPUL; tm_load = 1'b1; tm_val = CNT_W'(PULSE_N - 1);
      end
      ST_WPUL: if (tm_zero) begin
        tm_load = 1'b1;
        if (HOLD_N > 0) begin st_nxt = ST_WHLD; tm_val = CNT_W'(HOLD_N - 1); end
        else            begin st_nxt = ST_WREC; tm_val = CNT_W'(WREC_N - 1); end
      end
      ST_WHLD: if (tm_zero) begin
        st_nxt = ST_WREC; tm_load = 1'b1; tm_val = CNT_W'(WREC_N - 1);
      end
      ST_WREC: if (tm_zero) st_nxt = ST_IDLE;
      ST_RACC: if (tm_zero) begin
        st_nxt = ST_RREC; tm_load = 1'b1; tm_val = CNT_W'(RREC_N - 1);
      end
      ST_RREC: if (tm_zero) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign accept  = (st == ST_IDLE) && req;
  assign capture = (st == ST_RACC) && tm_zero;

  always_comb begin
    sel_nxt = (st_nxt == ST_WSET) || (st_nxt == ST_WPUL) ||
              (st_nxt == ST_WHLD) || (st_nxt == ST_RACC);
    rd_nxt  = (st_nxt == ST_RACC);
    wr_nxt  = (st_nxt == ST_WPUL);
    // bus is driven from the second pulse cycle, i.e. after WE is already low
    drv_nxt = (wr_nxt && st == ST_WPUL) || (st_nxt == ST_WHLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ce1_n <= 1'b1;
      ce2   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      st    <= st_nxt;
      ce1_n <= !sel_nxt;
      ce2   <= sel_nxt;
      oe_n  <= !rd_nxt;
      we_n  <= !wr_nxt;
      dq_oe <= drv_nxt;
      done  <= (st != ST_IDLE) && (st_nxt == ST_IDLE);
    end
  end

  // R3
  write_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce1_n && ce2 && oe_n));
  // R6
  read_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !ce1_n && ce2));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ce1_n && !ce2 && oe_n && we_n && !dq_oe && !done));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int AW_BITS = 17,
  parameter int DW_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               capture,
  input  logic [AW_BITS-1:0] req_addr,
  input  logic [DW_BITS-1:0] req_wdata,
  input  logic [DW_BITS-1:0] mem_dq_in,
  output logic [AW_BITS-1:0] mem_addr,
  output logic [DW_BITS-1:0] mem_dq_out,
  output logic [DW_BITS-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_ctl_pkg::*;
#(
  parameter int CLK_NS  = 4,
  parameter int AW_BITS = 17,
  parameter int DW_BITS = 8,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_AW_NS = 55,
  parameter int T_CW_NS = 55,
  parameter int T_DW_NS = 35,
  parameter int T_AS_NS = 0,
  parameter int T_DH_NS = 0,
  parameter int T_WR_NS = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               req_wr,
  input  logic [AW_BITS-1:0] req_addr,
  input  logic [DW_BITS-1:0] req_wdata,
  output logic [DW_BITS-1:0] rsp_rdata,
  output logic               rsp_done,
  output logic [AW_BITS-1:0] mem_addr,
  output logic               mem_ce1_n,
  output logic               mem_ce2,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [DW_BITS-1:0] mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DW_BITS-1:0] mem_dq_in
);
  localparam int WP_C = ns2cyc(T_WP_NS, CLK_NS);
  localparam int AW_C = ns2cyc(T_AW_NS, CLK_NS);
  localparam int CW_C = ns2cyc(T_CW_NS, CLK_NS);
  localparam int DW_C = ns2cyc(T_DW_NS, CLK_NS);
  localparam int WC_C = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WR_C = ns2cyc(T_WR_NS, CLK_NS);
  localparam int RC_C = ns2cyc(T_RC_NS, CLK_NS);

  localparam int SETUP_N = max2(ns2cyc(T_AS_NS, CLK_NS), 1);
  localparam int PULSE_N = max2(max2(WP_C, AW_C), max2(CW_C, DW_C + 1));
  localparam int HOLD_N  = ns2cyc(T_DH_NS, CLK_NS);
  localparam int WREC_N  = max2(max2(WR_C, 1), WC_C - SETUP_N - PULSE_N - HOLD_N);
  localparam int SAMP_N  = max2(max2(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)), 1);
  localparam int RREC_N  = max2(RC_C - SAMP_N, 1);
  localparam int MAX_N   = max2(max2(max2(SETUP_N, PULSE_N), max2(HOLD_N, WREC_N)),
                                max2(SAMP_N, RREC_N));
  localparam int CNT_W   = $clog2(MAX_N + 1);

  logic             tm_load, tm_zero, accept, capture;
  logic [CNT_W-1:0] tm_val;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .zero(tm_zero)
  );

  asram_seq #(
    .SETUP_N(SETUP_N), .PULSE_N(PULSE_N), .HOLD_N(HOLD_N), .WREC_N(WREC_N),
    .SAMP_N(SAMP_N), .RREC_N(RREC_N), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr),
    .tm_zero(tm_zero), .tm_load(tm_load), .tm_val(tm_val),
    .accept(accept), .capture(capture),
    .ce1_n(mem_ce1_n), .ce2(mem_ce2), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dq_oe(mem_dq_oe), .done(rsp_done)
  );

  asram_datapath #(.AW_BITS(AW_BITS), .DW_BITS(DW_BITS)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
  );

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n) && $past(mem_ce1_n) && !$past(mem_ce2)));
  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));
  // R4
  drive_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));
endmodule

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;
  localparam int P = 4;
  function automatic int cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + P - 1) / P;
  endfunction
  localparam int WP_C = cyc(50), CW_C = cyc(55), DW_C = cyc(35);
  localparam int WC_C = cyc(70), RC_C = cyc(70), AC_C = cyc(70);

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;
  logic rsp_done, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;

  always #2 clk = ~clk;

  async_sram_ctrl i_async_sram_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory model and expected contents
  bit [7:0] dev_m [int];
  bit [7:0] exp_m [int];
  function automatic bit [7:0] dev_rd(input int a);
    return dev_m.exists(a) ? dev_m[a] : 8'hC3;
  endfunction
  function automatic bit [7:0] exp_rd(input int a);
    return exp_m.exists(a) ? exp_m[a] : 8'hC3;
  endfunction

  int ovl_cnt = 0, sel_cnt = 0, dq_cnt = 0, rd_cnt = 0;
  bit p_ovl = 0, p_sel = 0, p_dqoe = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  logic [7:0]  dq_in_r = 8'h00;
  assign mem_dq_in = dq_in_r;

  always @(negedge clk) begin
    bit sel, ovl, rd;
    if (!rst) begin
      sel = !mem_ce1_n && mem_ce2;
      ovl = sel && !mem_we_n;
      rd  = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && !mem_oe_n) chk(0, "R4 bus contention", 1, 0);
      if (mem_dq_oe && mem_we_n)  chk(0, "R4 driven with WE high", 1, 0);
      if (p_sel && sel && mem_addr != p_addr) chk(0, "R5 address moved while selected", mem_addr, p_addr);
      if (p_ovl && !ovl) begin
        chk(ovl_cnt >= WP_C, "R3 write pulse width", ovl_cnt, WP_C);
        chk(sel_cnt >= CW_C, "R3 select to end of write", sel_cnt, CW_C);
        chk(dq_cnt >= DW_C && p_dqoe, "R4 data valid to end of write", dq_cnt, DW_C);
        dev_m[int'(p_addr)] = p_dq;
        ovl_cnt = 0;
        dq_cnt  = 0;
      end
      if (ovl) begin
        ovl_cnt++;
        dq_cnt = mem_dq_oe ? dq_cnt + 1 : 0;
      end
      sel_cnt = sel ? sel_cnt + 1 : 0;
      rd_cnt  = rd ? rd_cnt + 1 : 0;
      dq_in_r = (rd_cnt >= AC_C) ? dev_rd(int'(mem_addr)) : ~dev_rd(int'(mem_addr));
      p_ovl = ovl; p_sel = sel; p_dqoe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
    end
  end

  task automatic check_idle(input string rq);
    chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe, rq,
        {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
  endtask

  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        output int lat);
    int k;
    @(negedge clk); req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk); req = 0;
    k = 1;
    while (!rsp_done && k < 200) begin @(negedge clk); k++; end
    lat = k - 1;
    check_idle("R2 idle after operation");
    @(negedge clk);
    chk(!rsp_done, "R7 done lasts one cycle", rsp_done, 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int lat;
    run_op(1, a, d, lat);
    chk(lat >= WC_C && lat <= WC_C + 6, "R7 write cycle latency", lat, WC_C);
    exp_m[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a);
    int lat;
    logic [7:0] e;
    e = exp_rd(int'(a));
    run_op(0, a, 8'h00, lat);
    chk(lat >= RC_C && lat <= RC_C + 6, "R7 read cycle latency", lat, RC_C);
    chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] held;
    int dones;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check_idle("R1 strobes during reset");
    chk(!rsp_done, "R1 done during reset", rsp_done, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check_idle("R1 strobes after reset");

    // directed corners: address extremes
    do_write(17'h00000, 8'h11);
    do_write(17'h1FFFF, 8'hEE);
    do_read(17'h00000);
    do_read(17'h1FFFF);
    do_read(17'h00123); // never written

    // R9: read data survives a write
    do_read(17'h1FFFF);
    held = rsp_rdata;
    do_write(17'h00040, 8'h5C);
    chk(rsp_rdata == held, "R9 read data held over write", rsp_rdata, held);

    // R8: request during a write pulse is dropped
    @(negedge clk); req = 1; req_wr = 1; req_addr = 17'h00777; req_wdata = 8'hA1;
    @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
    req = 1; req_wr = 1; req_wdata = 8'h3E;
    @(negedge clk); req = 0; req_wr = 0;
    dones = 0;
    repeat (40) begin @(negedge clk); if (rsp_done) dones++; end
    chk(dones == 1, "R8 one done for busy-time request", dones, 1);
    exp_m[int'(17'h00777)] = 8'hA1;
    do_read(17'h00777);
    // R8: read request during a read is dropped too
    @(negedge clk); req = 1; req_wr = 0; req_addr = 17'h00777;
    @(negedge clk); req = 0;
    repeat (5) @(negedge clk);
    req = 1; req_addr = 17'h1FFFF;
    @(negedge clk); req = 0;
    dones = 0;
    repeat (40) begin @(negedge clk); if (rsp_done) dones++; end
    chk(dones == 1 && rsp_rdata == 8'hA1, "R8 read during read ignored", rsp_rdata, 8'hA1);

    // random mix: R3 R5 R6 exercised by monitor and read-back
    for (int i = 0; i < 120; i++) begin
      logic [16:0] a;
      a = 17'h10000 + 17'($urandom % 12);
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a);
    end
    for (int i = 0; i < 12; i++) do_read(17'h10000 + 17'(i));

    finish_up();
  end
endmodule